// File: doc/BRIEF.md
# Split/Shared Peripheral Data Path Controller

This block sits between a chip's internal transmit and receive FIFOs and a 64-pin external peripheral data bus with eight active-low byte enables. It decides every cycle whether a transfer takes place. It steers FIFO words and byte enables onto the pins, or captures them from the pins. It also produces the output-enable controls that the pad drivers need. Pad drivers are outside the block, so each pin group is exposed as a separate input, output and output-enable.

A static configuration bit selects the bus mode. It may only be changed while reset is asserted.

- **Shared mode:** all 64 pins form one bidirectional path. Writes and reads use the full width. A one-cycle turnaround separates a write and a read that follow each other.
- **Split mode:** the upper 32 pins carry transmit data and the lower 32 pins carry receive data. Each FIFO word moves as two half beats, low half first. The transmit half is always driven. The receive half is driven with a quiet pattern while reset is asserted and after a programmable number of cycles with no receive request.

A second static bit selects how the device select is encoded. In few-device mode it is one-hot for one or two slaves. In many-device mode it is a binary code for up to seven slaves.

Top module: `periph_dpath`

## Requirements
- R1: Shared mode, write beat. A write beat happens in the same cycle when all of these hold: `wr_req_i`, a valid device, `tx_empty_i` low, and the previous cycle was not a read beat. During that cycle `tx_pop_o`=1 and `bus_wr_o`=1. `bus_dat_o` equals `tx_data_i`, and `bus_ben_o` equals `tx_ben_i`. Both output-enable vectors are 2'b11.
- R2: Shared mode, read beat. A read beat happens when all of these hold: `rd_req_i`, no write is eligible, a valid device, `rx_full_i` low, and the previous cycle was not a write beat. During that cycle `bus_rd_o`=1 and `rx_push_o`=1. Both output-enable vectors are 2'b00. `rx_data_o` equals `bus_dat_i` and `rx_ben_o` equals `bus_ben_i`.
- R3: `tx_pop_o` is never high while `tx_empty_i` is high, and `rx_push_o` is never high while `rx_full_i` is high. A request blocked this way produces no bus beat.
- R4: Shared mode. When a write and a read are both eligible in one cycle, the write wins.
- R5: Shared mode, turnaround. A beat whose direction is opposite to the previous cycle's beat is held for one cycle. In that cycle there is no beat and neither pin group is driven.
- R6: Split mode, transmit. A 64-bit transmit word leaves on `bus_dat_o[63:32]` in two beats, bits 31:0 first. `bus_ben_o[7:4]` carries `tx_ben_i[3:0]` on the first beat and `tx_ben_i[7:4]` on the second. `tx_pop_o` fires on the second beat.
- R7: Split mode. `bus_dat_oe_o[1]` and `bus_ben_oe_o[1]` stay at 1 in every cycle, reset included. When no transmit beat is in progress, the upper half carries zero data and byte enables 4'hF.
- R8: Split mode, receive. Receive data is sampled from `bus_dat_i[31:0]` and `bus_ben_i[3:0]` in two beats, low half first. `rx_push_o` fires on the second beat with the assembled word. Transmit and receive beats may happen in the same cycle.
- R9: Split mode. While `rst_n` is low, the lower half is driven (`bus_dat_oe_o[0]` and `bus_ben_oe_o[0]` at 1) with zero data and byte enables 4'hF.
- R10: Split mode, idle drive. The lower half is driven when both of these hold: `rd_req_i` is low, and the count of consecutive earlier cycles without `rd_req_i` since reset is at least `cfg_idle_lim_i`. The count saturates at 255. The lower half is released in the same cycle that `rd_req_i` rises.
- R11: Shared mode. Neither pin group is driven in any cycle without a write beat, reset included.
- R12: Device select.
  - Few-device mode (`cfg_many_i`=0): device 0 gives `bus_dev_o`=3'b001 and device 1 gives 3'b010.
  - Many-device mode: device n (0..6) gives n+1.
  - An out-of-range device produces no beat.
  - `bus_dev_o` is 0 whenever there is no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_split_i | input | 1 | 1 = split halves, 0 = shared bidirectional path; change only in reset |
| cfg_many_i | input | 1 | 1 = up to seven slaves (binary select), 0 = one or two slaves (one-hot) |
| cfg_idle_lim_i | input | 8 | Idle cycles before the receive half is driven (split mode) |
| wr_req_i | input | 1 | Request to move transmit data to the bus |
| rd_req_i | input | 1 | Request to move bus data into the receive FIFO |
| dev_i | input | 3 | Target slave number |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_data_i | input | 64 | Transmit FIFO head word |
| tx_ben_i | input | 8 | Active-low byte enables of the head word |
| tx_pop_o | output | 1 | Consume the transmit head word |
| rx_full_i | input | 1 | Receive FIFO full |
| rx_push_o | output | 1 | Write a word into the receive FIFO |
| rx_data_o | output | 64 | Word for the receive FIFO |
| rx_ben_o | output | 8 | Active-low byte enables for the receive FIFO |
| bus_dat_i | input | 64 | Data pins as seen from the pads |
| bus_dat_o | output | 64 | Data toward the pads |
| bus_dat_oe_o | output | 2 | Output enable: bit 1 for pins 63:32, bit 0 for pins 31:0 |
| bus_ben_i | input | 8 | Byte-enable pins from the pads |
| bus_ben_o | output | 8 | Byte enables toward the pads (active low) |
| bus_ben_oe_o | output | 2 | Output enable: bit 1 for enables 7:4, bit 0 for enables 3:0 |
| bus_wr_o | output | 1 | Write beat strobe |
| bus_rd_o | output | 1 | Read beat strobe |
| bus_dev_o | output | 3 | Device select of the current beat |

## Verification
The hardest states to reach from the ports are two.

- **Split-mode idle drive.** It needs long stretches with no receive request. The stimulus therefore includes a phase where read requests are rare, run with limits of 3 and 0, so the lower half repeatedly parks and is released.
- **Shared-mode turnaround.** It needs a read and a write in consecutive cycles while the FIFO flags allow both. Dense random request phases, with full and empty flags raised only occasionally, produce many direction changes.

A behavioural reference model in the bench tracks:
- the previous beat direction;
- the half phases;
- the idle count.

It compares every output each cycle.

// File: rtl/pdp_pkg.sv
`timescale 1ns/1ps
package pdp_pkg;
    // direction of the beat in the previous cycle (shared mode)
    typedef enum logic [1:0] {
        LAST_NONE = 2'd0,
        LAST_WR   = 2'd1,
        LAST_RD   = 2'd2
    } pdp_last_e;
endpackage

// File: rtl/pdp_dev_enc.sv
`timescale 1ns/1ps
module pdp_dev_enc #(
    parameter int DEV_W = 3
) (
    input  logic             cfg_many_i,
    input  logic [DEV_W-1:0] dev_i,
    output logic             ok_o,
    output logic [DEV_W-1:0] code_o
);
    localparam int MANY_LIM = (1 << DEV_W) - 1;
    localparam int FEW_LIM  = 2;

    always_comb begin
        if (cfg_many_i) begin
            ok_o   = int'(dev_i) < MANY_LIM;
            code_o = dev_i + DEV_W'(1);
        end else begin
            ok_o   = int'(dev_i) < FEW_LIM;
            code_o = DEV_W'(1) << dev_i;
        end
        if (!ok_o) begin
            code_o = '0;
        end
    end
endmodule

// File: rtl/pdp_idle_park.sv
`timescale 1ns/1ps
module pdp_idle_park #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             rd_req_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             park_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } idle_st_t;

    idle_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_req_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != {CNT_W{1'b1}}) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        park_o = en_i && !rd_req_i && (st_q.cnt >= lim_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // any receive request hands the receive half back to the slave
    p_release_on_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |-> !park_o)
        else $error("receive half still driven while a read is requested");

    p_zero_limit_parks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !rd_req_i && lim_i == '0) |-> park_o)
        else $error("zero idle limit did not drive the receive half");
endmodule

// File: rtl/pdp_bidir_ctl.sv
`timescale 1ns/1ps
module pdp_bidir_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic wr_req_i,
    input  logic rd_req_i,
    input  logic dev_ok_i,
    input  logic tx_empty_i,
    input  logic rx_full_i,
    output logic wr_beat_o,
    output logic rd_beat_o
);
    import pdp_pkg::*;

    typedef struct packed {
        pdp_last_e last;
    } dir_st_t;

    dir_st_t st_d, st_q;
    logic    want_wr, want_rd, turn, wr_beat, rd_beat;

    always_comb begin
        want_wr = wr_req_i && dev_ok_i && !tx_empty_i;
        want_rd = rd_req_i && dev_ok_i && !rx_full_i && !want_wr;
        turn    = en_i && ((want_wr && st_q.last == LAST_RD) ||
                           (want_rd && st_q.last == LAST_WR));
        wr_beat = en_i && want_wr && (st_q.last != LAST_RD);
        rd_beat = en_i && want_rd && (st_q.last != LAST_WR);
        st_d    = st_q;
        if (wr_beat)      st_d.last = LAST_WR;
        else if (rd_beat) st_d.last = LAST_RD;
        else              st_d.last = LAST_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{last: LAST_NONE};
        else        st_q <= st_d;
    end

    assign wr_beat_o = wr_beat;
    assign rd_beat_o = rd_beat;

    p_rd_gap_before_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_beat |=> !wr_beat)
        else $error("write beat right after read beat");

    p_wr_gap_before_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_beat |=> !rd_beat)
        else $error("read beat right after write beat");

    p_turn_is_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        turn |-> !(wr_beat || rd_beat))
        else $error("beat issued in a turnaround cycle");

    p_write_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && rd_req_i && dev_ok_i && !tx_empty_i) |-> !rd_beat)
        else $error("read chosen over an eligible write");
endmodule

// File: rtl/pdp_split_ctl.sv
`timescale 1ns/1ps
module pdp_split_ctl #(
    parameter int DW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wr_req_i,
    input  logic              rd_req_i,
    input  logic              dev_ok_i,
    input  logic              tx_empty_i,
    input  logic              rx_full_i,
    input  logic [DW-1:0]     tx_data_i,
    input  logic [DW/8-1:0]   tx_ben_i,
    input  logic [DW/2-1:0]   rx_half_i,
    input  logic [DW/16-1:0]  rx_half_ben_i,
    output logic              wr_beat_o,
    output logic              rd_beat_o,
    output logic              tx_pop_o,
    output logic              rx_push_o,
    output logic [DW/2-1:0]   tx_half_o,
    output logic [DW/16-1:0]  tx_half_ben_o,
    output logic [DW-1:0]     rx_word_o,
    output logic [DW/8-1:0]   rx_word_ben_o
);
    localparam int HW  = DW / 2;
    localparam int BW  = DW / 8;
    localparam int HBW = BW / 2;

    typedef struct packed {
        logic           tx_ph;
        logic           rx_ph;
        logic [HW-1:0]  rx_lo;
        logic [HBW-1:0] rx_lo_ben;
    } half_st_t;

    half_st_t st_d, st_q;
    logic     wr_beat, rd_beat;

    always_comb begin
        wr_beat = en_i && wr_req_i && dev_ok_i && !tx_empty_i;
        rd_beat = en_i && rd_req_i && dev_ok_i && !rx_full_i;
        st_d    = st_q;
        if (wr_beat) begin
            st_d.tx_ph = !st_q.tx_ph;
        end
        if (rd_beat) begin
            st_d.rx_ph = !st_q.rx_ph;
            if (!st_q.rx_ph) begin
                st_d.rx_lo     = rx_half_i;
                st_d.rx_lo_ben = rx_half_ben_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_beat_o     = wr_beat;
    assign rd_beat_o     = rd_beat;
    assign tx_pop_o      = wr_beat && st_q.tx_ph;
    assign rx_push_o     = rd_beat && st_q.rx_ph;
    assign tx_half_o     = st_q.tx_ph ? tx_data_i[DW-1:HW] : tx_data_i[HW-1:0];
    assign tx_half_ben_o = st_q.tx_ph ? tx_ben_i[BW-1:HBW] : tx_ben_i[HBW-1:0];
    assign rx_word_o     = {rx_half_i, st_q.rx_lo};
    assign rx_word_ben_o = {rx_half_ben_i, st_q.rx_lo_ben};

    // a word takes two beats, so two pops can never be adjacent
    p_pop_every_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop_o |=> !tx_pop_o)
        else $error("transmit word popped after a single half");

    p_push_every_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push_o |=> !rx_push_o)
        else $error("receive word pushed after a single half");
endmodule

// File: rtl/periph_dpath.sv
`timescale 1ns/1ps
module periph_dpath #(
    parameter int DATA_W = 64,
    parameter int IDLE_W = 8,
    parameter int DEV_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_split_i,
    input  logic                  cfg_many_i,
    input  logic [IDLE_W-1:0]     cfg_idle_lim_i,
    input  logic                  wr_req_i,
    input  logic                  rd_req_i,
    input  logic [DEV_W-1:0]      dev_i,
    input  logic                  tx_empty_i,
    input  logic [DATA_W-1:0]     tx_data_i,
    input  logic [DATA_W/8-1:0]   tx_ben_i,
    output logic                  tx_pop_o,
    input  logic                  rx_full_i,
    output logic                  rx_push_o,
    output logic [DATA_W-1:0]     rx_data_o,
    output logic [DATA_W/8-1:0]   rx_ben_o,
    input  logic [DATA_W-1:0]     bus_dat_i,
    output logic [DATA_W-1:0]     bus_dat_o,
    output logic [1:0]            bus_dat_oe_o,
    input  logic [DATA_W/8-1:0]   bus_ben_i,
    output logic [DATA_W/8-1:0]   bus_ben_o,
    output logic [1:0]            bus_ben_oe_o,
    output logic                  bus_wr_o,
    output logic                  bus_rd_o,
    output logic [DEV_W-1:0]      bus_dev_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int BEN_W  = DATA_W / 8;
    localparam int HBEN_W = BEN_W / 2;

    logic              dev_ok;
    logic [DEV_W-1:0]  dev_code;
    logic              b_en, s_en;
    logic              b_wr, b_rd;
    logic              s_wr, s_rd, s_pop, s_push;
    logic [HALF_W-1:0] s_tx_half;
    logic [HBEN_W-1:0] s_tx_half_ben;
    logic [DATA_W-1:0] s_rx_word;
    logic [BEN_W-1:0]  s_rx_word_ben;
    logic              park, lo_drive;

    assign b_en = rst_n && !cfg_split_i;
    assign s_en = rst_n && cfg_split_i;

    pdp_dev_enc #(.DEV_W(DEV_W)) u_dev (
        .cfg_many_i (cfg_many_i),
        .dev_i      (dev_i),
        .ok_o       (dev_ok),
        .code_o     (dev_code)
    );

    pdp_bidir_ctl u_bidir (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (b_en),
        .wr_req_i   (wr_req_i),
        .rd_req_i   (rd_req_i),
        .dev_ok_i   (dev_ok),
        .tx_empty_i (tx_empty_i),
        .rx_full_i  (rx_full_i),
        .wr_beat_o  (b_wr),
        .rd_beat_o  (b_rd)
    );

    pdp_split_ctl #(.DW(DATA_W)) u_split (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (s_en),
        .wr_req_i      (wr_req_i),
        .rd_req_i      (rd_req_i),
        .dev_ok_i      (dev_ok),
        .tx_empty_i    (tx_empty_i),
        .rx_full_i     (rx_full_i),
        .tx_data_i     (tx_data_i),
        .tx_ben_i      (tx_ben_i),
        .rx_half_i     (bus_dat_i[HALF_W-1:0]),
        .rx_half_ben_i (bus_ben_i[HBEN_W-1:0]),
        .wr_beat_o     (s_wr),
        .rd_beat_o     (s_rd),
        .tx_pop_o      (s_pop),
        .rx_push_o     (s_push),
        .tx_half_o     (s_tx_half),
        .tx_half_ben_o (s_tx_half_ben),
        .rx_word_o     (s_rx_word),
        .rx_word_ben_o (s_rx_word_ben)
    );

    pdp_idle_park #(.CNT_W(IDLE_W)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (cfg_split_i),
        .rd_req_i (rd_req_i),
        .lim_i    (cfg_idle_lim_i),
        .park_o   (park)
    );

    assign lo_drive = !rst_n || park;

    always_comb begin
        if (cfg_split_i) begin
            bus_dat_o    = {(s_wr ? s_tx_half : {HALF_W{1'b0}}), {HALF_W{1'b0}}};
            bus_ben_o    = {(s_wr ? s_tx_half_ben : {HBEN_W{1'b1}}), {HBEN_W{1'b1}}};
            bus_dat_oe_o = {1'b1, lo_drive};
            bus_ben_oe_o = {1'b1, lo_drive};
            bus_wr_o     = s_wr;
            bus_rd_o     = s_rd;
            tx_pop_o     = s_pop;
            rx_push_o    = s_push;
            rx_data_o    = s_rx_word;
            rx_ben_o     = s_rx_word_ben;
        end else begin
            bus_dat_o    = b_wr ? tx_data_i : {DATA_W{1'b0}};
            bus_ben_o    = b_wr ? tx_ben_i : {BEN_W{1'b1}};
            bus_dat_oe_o = {b_wr, b_wr};
            bus_ben_oe_o = {b_wr, b_wr};
            bus_wr_o     = b_wr;
            bus_rd_o     = b_rd;
            tx_pop_o     = b_wr;
            rx_push_o    = b_rd;
            rx_data_o    = bus_dat_i;
            rx_ben_o     = bus_ben_i;
        end
        bus_dev_o = (bus_wr_o || bus_rd_o) ? dev_code : {DEV_W{1'b0}};
    end

    p_no_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop_o |-> !tx_empty_i)
        else $error("pop from empty transmit FIFO");

    p_no_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push_o |-> !rx_full_i)
        else $error("push into full receive FIFO");

    p_tx_half_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_split_i |-> (bus_dat_oe_o[1] && bus_ben_oe_o[1]))
        else $error("transmit half released in split mode");

    p_read_releases_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_split_i && bus_rd_o) |-> (bus_dat_oe_o == 2'b00 && bus_ben_oe_o == 2'b00))
        else $error("pins driven during a shared-mode read");

    p_shared_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_split_i && !bus_wr_o) |-> (bus_dat_oe_o == 2'b00))
        else $error("shared bus driven without a write");

    p_few_dev_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_many_i && (bus_wr_o || bus_rd_o)) |-> ($countones(bus_dev_o) == 1))
        else $error("few-device select is not one-hot");

    p_no_beat_no_dev_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_o || bus_rd_o) |-> (bus_dev_o == '0))
        else $error("device select active without a beat");
endmodule

// File: tb/periph_dpath_test.sv
`timescale 1ns/1ps
module periph_dpath_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_split, cfg_many;
    logic [7:0]  lim;
    logic        wr_req, rd_req;
    logic [2:0]  dev;
    logic        tx_empty, rx_full;
    logic [63:0] tx_data, bus_dat_in;
    logic [7:0]  tx_ben, bus_ben_in;
    logic        tx_pop, rx_push, bus_wr, bus_rd;
    logic [63:0] rx_data, bus_dat_out;
    logic [7:0]  rx_ben, bus_ben_out;
    logic [1:0]  dat_oe, ben_oe;
    logic [2:0]  bus_dev;

    int checks = 0;
    int errors = 0;

    // reference model state
    int          m_last = 0;   // 0 none, 1 write, 2 read
    bit          m_txph = 0, m_rxph = 0;
    logic [31:0] m_rxlo = '0;
    logic [3:0]  m_rxloben = '0;
    int          m_idle = 0;

    always #4 clk = ~clk;   // 8 ns period

    periph_dpath uut (
        .clk(clk), .rst_n(rst_n), .cfg_split_i(cfg_split), .cfg_many_i(cfg_many),
        .cfg_idle_lim_i(lim), .wr_req_i(wr_req), .rd_req_i(rd_req), .dev_i(dev),
        .tx_empty_i(tx_empty), .tx_data_i(tx_data), .tx_ben_i(tx_ben), .tx_pop_o(tx_pop),
        .rx_full_i(rx_full), .rx_push_o(rx_push), .rx_data_o(rx_data), .rx_ben_o(rx_ben),
        .bus_dat_i(bus_dat_in), .bus_dat_o(bus_dat_out), .bus_dat_oe_o(dat_oe),
        .bus_ben_i(bus_ben_in), .bus_ben_o(bus_ben_out), .bus_ben_oe_o(ben_oe),
        .bus_wr_o(bus_wr), .bus_rd_o(bus_rd), .bus_dev_o(bus_dev)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    // compare all outputs for the present cycle, then advance the model
    task automatic step();
        logic [63:0] e_dat, e_rxd;
        logic [7:0]  e_ben, e_rxb;
        logic [1:0]  e_oe;
        logic [2:0]  e_dev;
        logic        e_wr, e_rd;
        bit          ok_dev, ww, wd, lo_on;
        string       t_str;
        ok_dev = cfg_many ? (dev < 3'd7) : (dev < 3'd2);
        e_wr = 1'b0;
        e_rd = 1'b0;
        if (!cfg_split) begin
            ww = wr_req && ok_dev && !tx_empty;
            wd = !ww && rd_req && ok_dev && !rx_full;
            if (rst_n) begin
                e_wr = ww && (m_last != 2);
                e_rd = wd && (m_last != 1);
            end
            e_dat = e_wr ? tx_data : 64'h0;
            e_ben = e_wr ? tx_ben : 8'hFF;
            e_oe  = e_wr ? 2'b11 : 2'b00;
            e_rxd = bus_dat_in;
            e_rxb = bus_ben_in;
            chk("R1", bus_dat_out, e_dat);
            chk("R1", bus_ben_out, e_ben);
            chk("R11", dat_oe, e_oe);
            chk("R11", ben_oe, e_oe);
            t_str = (wr_req && rd_req) ? "R4" : "R5";
            if (e_rd) begin
                chk("R2", rx_data, e_rxd);
                chk("R2", rx_ben, e_rxb);
            end
        end else begin
            if (rst_n) begin
                e_wr = wr_req && ok_dev && !tx_empty;
                e_rd = rd_req && ok_dev && !rx_full;
            end
            e_dat = {(e_wr ? (m_txph ? tx_data[63:32] : tx_data[31:0]) : 32'h0), 32'h0};
            e_ben = {(e_wr ? (m_txph ? tx_ben[7:4] : tx_ben[3:0]) : 4'hF), 4'hF};
            lo_on = !rst_n || (!rd_req && m_idle >= int'(lim));
            e_rxd = {bus_dat_in[31:0], m_rxlo};
            e_rxb = {bus_ben_in[3:0], m_rxloben};
            chk("R6", bus_dat_out, e_dat);
            chk("R6", bus_ben_out, e_ben);
            chk("R7", {dat_oe[1], ben_oe[1]}, 2'b11);
            chk(rst_n ? "R10" : "R9", {dat_oe[0], ben_oe[0]}, {lo_on, lo_on});
            t_str = "R8";
            if (e_rd && m_rxph) begin
                chk("R8", rx_data, e_rxd);
                chk("R8", rx_ben, e_rxb);
            end
        end
        chk(t_str, bus_wr, e_wr);
        chk(t_str, bus_rd, e_rd);
        chk("R3", tx_pop, cfg_split ? (e_wr && m_txph) : e_wr);
        chk("R3", rx_push, cfg_split ? (e_rd && m_rxph) : e_rd);
        e_dev = (e_wr || e_rd) ? (cfg_many ? 3'(dev + 3'd1) : 3'(3'd1 << dev)) : 3'd0;
        chk("R12", bus_dev, e_dev);

        if (!rst_n) begin
            m_last = 0; m_txph = 0; m_rxph = 0; m_rxlo = '0; m_rxloben = '0; m_idle = 0;
        end else begin
            m_last = cfg_split ? 0 : (e_wr ? 1 : (e_rd ? 2 : 0));
            if (cfg_split && e_wr) m_txph = !m_txph;
            if (cfg_split && e_rd) begin
                if (!m_rxph) begin
                    m_rxlo    = bus_dat_in[31:0];
                    m_rxloben = bus_ben_in[3:0];
                end
                m_rxph = !m_rxph;
            end
            if (rd_req) m_idle = 0;
            else if (m_idle < 255) m_idle++;
        end
    endtask

    task automatic run(input int n, input int p_wr, input int p_rd,
                       input int p_flag, input int p_bad);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_req   = ($urandom % 100) < p_wr;
            rd_req   = ($urandom % 100) < p_rd;
            tx_empty = ($urandom % 100) < p_flag;
            rx_full  = ($urandom % 100) < p_flag;
            if (($urandom % 100) < p_bad) dev = 3'($urandom);
            else dev = cfg_many ? 3'($urandom % 7) : 3'($urandom % 2);
            tx_data    = {$urandom, $urandom};
            tx_ben     = 8'($urandom);
            bus_dat_in = {$urandom, $urandom};
            bus_ben_in = 8'($urandom);
            #1;
            step();
        end
    endtask

    task automatic do_reset(input logic split, input logic many);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_split = split;
        cfg_many = many;
        run(3, 50, 50, 10, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_split = 1'b0; cfg_many = 1'b0; lim = 8'd3;
        wr_req = 0; rd_req = 0; dev = '0; tx_empty = 1; rx_full = 0;
        tx_data = '0; tx_ben = '1; bus_dat_in = '0; bus_ben_in = '1;
        // shared mode: reset quiet (R11), beats, priority, turnaround, FIFO guards
        do_reset(1'b0, 1'b0);
        run(1500, 50, 50, 10, 10);
        run(500, 90, 90, 5, 0);
        do_reset(1'b0, 1'b1);
        run(1500, 50, 50, 10, 15);
        // split mode: reset drive (R9), halves, idle drive (R10)
        do_reset(1'b1, 1'b0);
        run(1500, 50, 50, 10, 10);
        lim = 8'd3;
        run(800, 40, 8, 5, 0);
        lim = 8'd0;
        run(400, 40, 20, 5, 0);
        do_reset(1'b1, 1'b1);
        lim = 8'd5;
        run(1200, 60, 30, 10, 15);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule